// File: doc/BRIEF.md
# Multi-Bank Memory Access Scheduler

This block places the memory accesses of one instruction cycle onto a single shared address/data bus. The bus reaches four physically separate banks: three on-chip RAMs of 512 words of 32 bits each, and one off-chip bank. Instructions and data share one byte-addressed space, and any of the four requests may fall in any bank. Each instruction cycle can carry up to four requests: an instruction fetch, two operand reads and a result write. The pipeline hands them over as one set with a start pulse.

The scheduler gives the set a frame of four bus slots. The slot number equals the request index. A bank serves at most one access per frame. The lowest-index valid request to a bank gets the slot that carries its index. A valid request that meets a lower-index valid request in the same bank is deferred. Each deferred request is served after the frame in its own wait slot, in ascending index order. A stall output tells the pipeline that such wait slots are in progress.

In every slot the block drives a one-hot bank enable, the 22-bit word address, four byte-lane selects, a write strobe and the index of the request being served. The lane selects come from the two low address bits and the access size. A done pulse marks the last slot of a cycle. A new set can be started in that same slot, so cycles run back to back.

Top module: `bank_access_sched`

## Requirements
- R1: The word address is the byte address with its two low bits dropped. Word addresses 0..511 select bank 0, 512..1023 select bank 1 and 1024..1535 select bank 2. Every other word address selects bank 3, the external bank. Bank k is bit k of `bank_en_o`. In a slot that serves a request exactly one bit is set; in a slot that serves nothing all bits are 0.
- R2: In a slot that serves a request, `waddr_o` equals bits 23..2 of that request's byte address. In an idle slot `waddr_o` is 0.
- R3: Lane select bit i enables byte i of the word. Size code 0 (byte) enables lane 1<<addr[1:0]. Size code 1 (halfword) enables 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1; addr[0] is ignored. Size codes 2 and 3 (word) enable 4'b1111. In an idle slot `bsel_o` is 0.
- R4: Request 0 is the instruction fetch. It always uses 4'b1111 lanes, whatever its size code. Requests 1 and 2 are reads and request 3 is the write. `we_o` is 1 only in a slot that serves request 3. `req_id_o` gives the index of the request being served.
- R5: A start is accepted at a clock edge where `start_i` and `ready_o` are both 1. The next four slots, numbered 0..3, form the frame. Slot k serves request k if it is valid and no lower-index valid request targets the same bank; otherwise slot k is idle.
- R6: Each request deferred under R5 is served after the frame, one per slot, in ascending index order. Bank, address, size and valid values are captured at acceptance. Later changes on the request inputs do not affect the cycle.
- R7: `stall_o` is 1 exactly in the post-frame slots. The number of such slots equals the number of deferred requests.
- R8: `done_o` is 1 only in the last slot of a cycle: frame slot 3 when nothing is deferred, otherwise the last post-frame slot. `ready_o` is 1 when idle or in a done slot. A start while `ready_o` is 0 is ignored.
- R9: While reset is held and after it is released, all bus outputs, `stall_o` and `done_o` are 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Offers a new request set |
| req_valid_i | input | 4 | Per-request valid, index 0 fetch, 1..2 reads, 3 write |
| req_addr_i | input | 4x24 | Per-request byte address |
| req_size_i | input | 4x2 | Per-request size code (0 byte, 1 half, 2/3 word) |
| ready_o | output | 1 | A start is accepted at the next edge |
| bank_en_o | output | 4 | One-hot bank enable for the current slot |
| waddr_o | output | 22 | Word address on the shared bus |
| bsel_o | output | 4 | Byte-lane selects |
| we_o | output | 1 | Write strobe |
| req_id_o | output | 2 | Index of the request served in this slot |
| stall_o | output | 1 | Wait slot in progress; pipeline must hold |
| done_o | output | 1 | Last slot of the current cycle |

## Verification
The assertions assume that the pipeline holds `start_i` only as an offer. They take a one-cycle stall gap or a non-write `req_id_o` as meaningful only in slots the block itself produces, and they need no promise about the request inputs beyond reset. The stimulus offers a start only at a falling edge where `ready_o` reads 1, except for deliberate starts placed in the middle of a frame to test the ignore rule. Right after acceptance it scrambles the request addresses to show that the captured values are used. It covers every combination of valid pattern and bank assignment, with addresses placed on the window edges.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

endpackage

// File: rtl/bas_bank_decode.sv
module bas_bank_decode #(
    parameter int WADDR_W   = 22,
    parameter int N_RAM     = 3,
    parameter int RAM_WORDS = 512
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic [N_RAM:0]     bank_oh
);
    localparam int RAM_AW = $clog2(RAM_WORDS);

    logic [WADDR_W-1:0] blk;
    logic [N_RAM-1:0]   hit;

    assign blk = waddr >> RAM_AW;

    for (genvar k = 0; k < N_RAM; k++) begin : g_win
        assign hit[k] = (blk == WADDR_W'(k));
    end

    // anything outside the on-chip windows goes off chip
    assign bank_oh = {~|hit, hit};

endmodule

// File: rtl/bas_lane_sel.sv
module bas_lane_sel #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lo,
    input  bas_pkg::size_e           sz,
    input  logic                     force_word,
    output logic [LANES-1:0]         bsel
);
    localparam int LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] half_base;

    always_comb begin
        half_base = {lo[LANE_W-1:1], 1'b0};
        if (force_word) begin
            bsel = '1;
        end else begin
            case (sz)
                bas_pkg::SZ_BYTE: bsel = LANES'(1) << lo;
                bas_pkg::SZ_HALF: bsel = LANES'(3) << half_base;
                default:          bsel = '1;
            endcase
        end
    end

endmodule

// File: rtl/bas_conflict.sv
module bas_conflict #(
    parameter int NREQ  = 4,
    parameter int NBANK = 4
) (
    input  logic [NREQ-1:0]            valid,
    input  logic [NREQ-1:0][NBANK-1:0] bank,
    output logic [NREQ-1:0]            defer
);
    // a request loses its frame slot to any lower-index valid request
    // aimed at the same bank
    always_comb begin
        defer = '0;
        for (int i = 1; i < NREQ; i++) begin
            for (int j = 0; j < i; j++) begin
                if (valid[i] && valid[j] && (bank[i] == bank[j])) begin
                    defer[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bank_access_sched.sv
module bank_access_sched #(
    parameter int NREQ      = 4,
    parameter int ADDR_W    = 24,
    parameter int LANES     = 4,
    parameter int N_RAM     = 3,
    parameter int RAM_WORDS = 512
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_i,
    input  logic [NREQ-1:0]                        req_valid_i,
    input  logic [NREQ-1:0][ADDR_W-1:0]            req_addr_i,
    input  logic [NREQ-1:0][1:0]                   req_size_i,
    output logic                                   ready_o,
    output logic [N_RAM:0]                         bank_en_o,
    output logic [ADDR_W-$clog2(LANES)-1:0]        waddr_o,
    output logic [LANES-1:0]                       bsel_o,
    output logic                                   we_o,
    output logic [$clog2(NREQ)-1:0]                req_id_o,
    output logic                                   stall_o,
    output logic                                   done_o
);
    localparam int NBANK   = N_RAM + 1;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WADDR_W = ADDR_W - LANE_W;
    localparam int SLOT_W  = $clog2(NREQ);
    localparam int WR_IDX  = NREQ - 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NREQ - 1);

    typedef struct packed {
        logic                             busy;
        logic                             extra;
        logic [SLOT_W-1:0]                slot;
        logic [NREQ-1:0]                  valid;
        logic [NREQ-1:0]                  defer;
        logic [NREQ-1:0]                  pend;
        logic [NREQ-1:0][ADDR_W-1:0]      addr;
        logic [NREQ-1:0][1:0]             size;
        logic [NBANK-1:0]                 bank_en;
        logic [WADDR_W-1:0]               waddr;
        logic [LANES-1:0]                 bsel;
        logic                             we;
        logic [SLOT_W-1:0]                id;
        logic                             stall;
        logic                             done;
    } state_t;

    state_t st_d, st_q;

    logic                            accept;
    logic [NREQ-1:0]                 cur_valid;
    logic [NREQ-1:0][ADDR_W-1:0]     cur_addr;
    logic [NREQ-1:0][1:0]            cur_size;
    logic [NREQ-1:0][NBANK-1:0]      cur_bank;
    logic [NREQ-1:0][LANES-1:0]      cur_bsel;
    logic [NREQ-1:0]                 cur_defer;
    logic                            sel_valid;
    logic [SLOT_W-1:0]               sel_idx;

    assign ready_o = ~st_q.busy | st_q.done;
    assign accept  = start_i & ready_o;

    // on acceptance the slot-0 decision uses the live inputs;
    // afterwards every slot works from the captured set
    assign cur_valid = accept ? req_valid_i : st_q.valid;
    assign cur_addr  = accept ? req_addr_i  : st_q.addr;
    assign cur_size  = accept ? req_size_i  : st_q.size;

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        bas_bank_decode #(
            .WADDR_W  (WADDR_W),
            .N_RAM    (N_RAM),
            .RAM_WORDS(RAM_WORDS)
        ) dec_i (
            .waddr  (cur_addr[i][ADDR_W-1:LANE_W]),
            .bank_oh(cur_bank[i])
        );

        bas_lane_sel #(
            .LANES(LANES)
        ) lane_i (
            .lo        (cur_addr[i][LANE_W-1:0]),
            .sz        (bas_pkg::size_e'(cur_size[i])),
            .force_word(i == 0),
            .bsel      (cur_bsel[i])
        );
    end

    bas_conflict #(
        .NREQ (NREQ),
        .NBANK(NBANK)
    ) conf_i (
        .valid(cur_valid),
        .bank (cur_bank),
        .defer(cur_defer)
    );

    always_comb begin
        st_d         = st_q;
        st_d.bank_en = '0;
        st_d.waddr   = '0;
        st_d.bsel    = '0;
        st_d.we      = 1'b0;
        st_d.id      = '0;
        st_d.stall   = 1'b0;
        st_d.done    = 1'b0;
        sel_valid    = 1'b0;
        sel_idx      = '0;

        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.extra = 1'b0;
            st_d.slot  = '0;
            st_d.valid = req_valid_i;
            st_d.addr  = req_addr_i;
            st_d.size  = req_size_i;
            st_d.defer = cur_defer;
            st_d.pend  = cur_defer;
            sel_idx    = '0;
            sel_valid  = req_valid_i[0] & ~cur_defer[0];
            st_d.done  = (LAST_SLOT == '0) && (cur_defer == '0);
        end else if (!st_q.busy || st_q.done) begin
            st_d.busy  = 1'b0;
            st_d.extra = 1'b0;
        end else if (!st_q.extra && (st_q.slot != LAST_SLOT)) begin
            st_d.slot = st_q.slot + SLOT_W'(1);
            sel_idx   = st_d.slot;
            sel_valid = st_q.valid[st_d.slot] & ~st_q.defer[st_d.slot];
            st_d.done = (st_d.slot == LAST_SLOT) && (st_q.pend == '0);
        end else begin
            // wait slot: lowest pending index first
            st_d.extra = 1'b1;
            for (int i = NREQ - 1; i >= 0; i--) begin
                if (st_q.pend[i]) begin
                    sel_idx = SLOT_W'(i);
                end
            end
            sel_valid          = st_q.pend[sel_idx];
            st_d.pend[sel_idx] = 1'b0;
            st_d.stall         = 1'b1;
            st_d.done          = (st_d.pend == '0);
        end

        if (sel_valid) begin
            st_d.bank_en = cur_bank[sel_idx];
            st_d.waddr   = cur_addr[sel_idx][ADDR_W-1:LANE_W];
            st_d.bsel    = cur_bsel[sel_idx];
            st_d.we      = (sel_idx == SLOT_W'(WR_IDX));
            st_d.id      = sel_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_en_o = st_q.bank_en;
    assign waddr_o   = st_q.waddr;
    assign bsel_o    = st_q.bsel;
    assign we_o      = st_q.we;
    assign req_id_o  = st_q.id;
    assign stall_o   = st_q.stall;
    assign done_o    = st_q.done;

endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
    parameter int NBANK  = 4,
    parameter int LANES  = 4,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NBANK-1:0]  bank_en_o,
    input logic [LANES-1:0]  bsel_o,
    input logic              we_o,
    input logic [SLOT_W-1:0] req_id_o,
    input logic              stall_o,
    input logic              done_o,
    input logic              ready_o
);
    // R1
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en_o));

    // R3
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en_o == '0) |-> (bsel_o == '0));

    // R4
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ((req_id_o == '1) && (bank_en_o != '0)));

    // R7
    stall_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (bank_en_o != '0));

    // R7
    stall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !done_o) |=> stall_o);

    // R8
    done_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !stall_o);

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o);

endmodule

bind bank_access_sched bas_chk #(
    .NBANK (N_RAM + 1),
    .LANES (LANES),
    .SLOT_W($clog2(NREQ))
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_en_o(bank_en_o),
    .bsel_o   (bsel_o),
    .we_o     (we_o),
    .req_id_o (req_id_o),
    .stall_o  (stall_o),
    .done_o   (done_o),
    .ready_o  (ready_o)
);

// File: tb/bank_access_sched_tb.sv
module bank_access_sched_tb_top;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       req_valid_i = '0;
    logic [3:0][23:0] req_addr_i = '0;
    logic [3:0][1:0]  req_size_i = '0;
    logic             ready_o;
    logic [3:0]       bank_en_o;
    logic [21:0]      waddr_o;
    logic [3:0]       bsel_o;
    logic             we_o;
    logic [1:0]       req_id_o;
    logic             stall_o;
    logic             done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [23:0] t_addr [4];
    logic [1:0]  t_size [4];

    always #2 clk = ~clk;

    bank_access_sched dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_size_i(req_size_i), .ready_o(ready_o),
        .bank_en_o(bank_en_o), .waddr_o(waddr_o), .bsel_o(bsel_o),
        .we_o(we_o), .req_id_o(req_id_o), .stall_o(stall_o),
        .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [3:0] exp_bank(input logic [23:0] a);
        int w;
        w = int'(a >> 2) / 512;
        if (w < 3) return 4'(1 << w);
        return 4'b1000;
    endfunction

    function automatic logic [3:0] exp_lanes(input int idx, input logic [23:0] a, input logic [1:0] s);
        if (idx == 0 || s >= 2) return 4'hF;
        if (s == 0) return 4'(1 << a[1:0]);
        return a[1] ? 4'hC : 4'h3;
    endfunction

    function automatic logic [21:0] mk_word(input int b, input int sel, input int i);
        if (b < 3) begin
            if (sel == 0) return 22'(b * 512);
            if (sel == 1) return 22'(b * 512 + 511);
            return 22'(b * 512 + 100 + i);
        end
        if (sel == 0) return 22'd1536;
        if (sel == 1) return 22'h3FFFFF;
        return 22'(200000 + i);
    endfunction

    // caller is at a falling edge with ready_o high
    task automatic run_txn(input logic [3:0] vp, input bit spurious);
        bit dfr [4];
        int order [8];
        int total;
        int idx;
        bit issue;
        total = 4;
        for (int i = 0; i < 4; i++) begin
            dfr[i] = 1'b0;
            for (int j = 0; j < i; j++)
                if (vp[i] && vp[j] && exp_bank(t_addr[i]) == exp_bank(t_addr[j])) dfr[i] = 1'b1;
        end
        for (int i = 0; i < 4; i++) begin
            if (dfr[i]) begin
                order[total] = i;
                total++;
            end
        end
        start_i = 1'b1;
        req_valid_i = vp;
        for (int i = 0; i < 4; i++) begin
            req_addr_i[i] = t_addr[i];
            req_size_i[i] = t_size[i];
        end
        for (int s = 0; s < total; s++) begin
            @(negedge clk);
            if (s == 0) begin
                start_i = 1'b0;
                for (int i = 0; i < 4; i++) req_addr_i[i] = ~t_addr[i];
                req_valid_i = ~vp;
            end
            if (s < 4) begin
                idx = s;
                issue = vp[s] && !dfr[s];
            end else begin
                idx = order[s];
                issue = 1'b1;
            end
            if (issue) begin
                chk(s < 4 ? "R1 R5 bank" : "R1 R6 bank", 32'(bank_en_o), 32'(exp_bank(t_addr[idx])));
                chk("R2 waddr", 32'(waddr_o), 32'(t_addr[idx] >> 2));
                chk(idx == 0 ? "R4 fetch lanes" : "R3 lanes", 32'(bsel_o),
                    32'(exp_lanes(idx, t_addr[idx], t_size[idx])));
                chk("R4 id", 32'(req_id_o), 32'(idx));
                chk("R4 we", 32'(we_o), 32'(idx == 3));
            end else begin
                chk("R5 idle bank", 32'(bank_en_o), 32'd0);
                chk("R5 idle bus", {8'(bsel_o), 22'(waddr_o), 1'b0, we_o}, 32'd0);
            end
            chk("R7 stall", 32'(stall_o), 32'(s >= 4));
            chk("R8 done", 32'(done_o), 32'(s == total - 1));
            chk("R8 ready", 32'(ready_o), 32'(s == total - 1));
            if (s == 1 && spurious) begin
                start_i = 1'b1;
                req_valid_i = 4'hF;
            end else if (s == 2) begin
                start_i = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 during reset
        chk("R9 reset bus", {bank_en_o, bsel_o, 2'(req_id_o), 22'(waddr_o)}, 32'd0);
        chk("R9 reset flags", {29'd0, stall_o, done_o, ready_o}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {25'd0, bank_en_o, we_o, stall_o, done_o}, 32'd0);
        chk("R9 ready after reset", 32'(ready_o), 32'd1);

        for (int vp = 0; vp < 16; vp++) begin
            for (int c = 0; c < 256; c++) begin
                for (int i = 0; i < 4; i++) begin
                    t_addr[i] = {mk_word((c >> (2 * i)) & 3, (c + vp + i) % 3, i), 2'((c + i) & 3)};
                    t_size[i] = 2'((vp + c + 3 * i) & 3);
                end
                run_txn(4'(vp), (c % 5) == 0);
            end
        end

        // R8: after the last done with no start, the block goes idle
        @(negedge clk);
        chk("R8 idle after done", {29'd0, bank_en_o[0], stall_o, done_o}, 32'd0);
        chk("R8 ready idle", 32'(ready_o), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule